// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command strobes of a four-bank single-data-rate SDRAM from the device side. On every rising clock edge it samples chip select, the row and column strobes, write enable, the bank-select bits and the address bus. It turns that sample into a command code, and it keeps for each bank whether it is open, which row it holds and how long it stays locked after a precharge. Commands that break the bank rules are reported with a violation flag and change nothing.

A command sampled at one edge is reported on the registered outputs right after that edge. The report holds the code, the bank, the row or column address, the open row of the addressed bank for reads and writes, and the violation flag. An accepted write opens a write-capture window at once. An accepted read opens a read-data-valid window after the CAS latency. Each window lasts for the burst length. CAS latency and burst length are static inputs. The precharge-to-activate lockout is a parameter.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` low, the `{ras_n,cas_n,we_n}` patterns decode as follows: 011 is activate (code 1), 101 is read (code 2), 100 is write (code 3), and 010 is precharge. Precharge reports code 4 when `addr[10]` is low and code 5 when `addr[10]` is high.
- R2: When `cs_n` is high, or for any other strobe pattern, the result is code 0. The violation flag stays low, `cmd_bank`, `cmd_addr` and `cmd_row` are 0, and no bank changes state.
- R3: An activate to an idle bank whose lockout has expired opens the bank, stores the row and reports `cmd_addr` equal to the row. An activate to a bank that is already open raises the violation flag and keeps the stored row.
- R4: A precharge with `addr[10]` low closes only the bank named by `ba`. The other banks stay open.
- R5: A precharge with `addr[10]` high closes all four banks, whatever the value of `ba`.
- R6: Suppose a bank was precharged at edge p. An activate to it at edge n is accepted only when n - p >= TRP. An earlier activate raises the violation flag and leaves the bank idle.
- R7: A read or write to a bank that is not open raises the violation flag, reports `cmd_row` 0 and starts no data strobe.
- R8: For a write accepted at edge n, `wr_capture` is high after edges n through n+BL-1.
- R9: For a read accepted at edge n with CAS latency CL (1 to 3), `rd_valid` is high after edges n+CL through n+CL+BL-1.
- R10: `burst_sel` values 0, 1, 2 and 3 give BL of 1, 2, 4 and 8. A new accepted command of the same kind restarts its window.
- R11: While `rst` is high at an edge, all outputs clear to 0. All banks become idle, with no lockout pending.
- R12: The result of the command sampled at edge n appears right after edge n. For read and write, `cmd_addr` is the low COL_W address bits, zero-extended. For precharge, `cmd_addr` is 0. For every command other than a no-operation, `cmd_bank` equals `ba`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus: row for activate, column for read or write, bit 10 selects all-bank precharge |
| cas_lat | input | 2 | CAS latency in cycles, 1 to 3 (static) |
| burst_sel | input | 2 | Burst length code, BL = 2^code (static) |
| cmd_code | output | 3 | Decoded command: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge all |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_addr | output | 12 | Row (activate) or zero-extended column (read, write) |
| cmd_row | output | 12 | Open row of the addressed bank for read or write, else 0 |
| viol | output | 1 | The reported command broke a bank rule and was ignored |
| rd_valid | output | 1 | Read data window |
| wr_capture | output | 1 | Write data capture window |

## Verification
Two functions share a cycle when a read is followed at once by a write to the same open bank. The delayed read window then lies over the start of the write window. The bench runs this for every CAS latency and burst code. A per-cycle monitor holds an independent list of window start edges for each strobe and judges `rd_valid` and `wr_capture` separately against it, so a strobe that leaks into the other or takes the other's timing is caught. A second overlap puts a precharge and the lockout counter in the same cycle. Precharge-to-activate gaps are swept for every bank.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5
  } sdr_cmd_t;

  // burst length in beats from the 2-bit selector
  function automatic logic [3:0] burst_beats(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  input  logic     all_banks,
  output sdr_cmd_t cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = all_banks ? CMD_PALL : CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int ROW_W = 12,
  parameter int TRP   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_en,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic             ready,
  output logic [ROW_W-1:0] row_q
);

  localparam int CNT_W = (TRP < 1) ? 1 : $clog2(TRP + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'((TRP < 1) ? 0 : TRP - 1);

  logic [CNT_W-1:0] lock_cnt;

  assign ready = (lock_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      lock_cnt <= '0;
      row_q    <= '0;
    end else begin
      if (pre_en) begin
        is_open  <= 1'b0;
        lock_cnt <= RELOAD;
      end else begin
        if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
        if (act_en) begin
          is_open <= 1'b1;
          row_q   <= row_in;
        end
      end
    end
  end

endmodule

// File: rtl/sdr_burst_strobe.sv
module sdr_burst_strobe
  import sdr_trk_pkg::*;
#(
  parameter int MAX_DLY = 3,
  parameter int DLY_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  input  logic [1:0]       bl_sel,
  output logic             strobe
);

  logic [MAX_DLY-1:0] pipe;
  logic [MAX_DLY:0]   taps;
  logic               launch;
  logic [2:0]         left;
  logic [3:0]         beats;

  assign taps   = {pipe, start};
  assign launch = taps[dly];
  assign beats  = burst_beats(bl_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe   <= '0;
      left   <= '0;
      strobe <= 1'b0;
    end else begin
      pipe[0] <= start;
      for (int i = 1; i < MAX_DLY; i++) pipe[i] <= pipe[i-1];
      strobe <= launch || (left != '0);
      if (launch)          left <= 3'(beats - 4'd1);
      else if (left != '0) left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ADDR_W  = 12,
  parameter int COL_W   = 8,
  parameter int ALL_BIT = 10,
  parameter int TRP     = 3,
  parameter int MAX_CL  = 3,
  localparam int BA_W   = $clog2(BANKS),
  localparam int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic [1:0]        burst_sel,
  output logic [2:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_row,
  output logic              viol,
  output logic              rd_valid,
  output logic              wr_capture
);

  sdr_cmd_t          cmd;
  logic [BANKS-1:0]  open_v, ready_v, act_en, pre_en;
  logic [ADDR_W-1:0] row_q [BANKS];
  logic              viol_c, rd_ok, wr_ok;
  logic [ADDR_W-1:0] col_ext;

  sdr_cmd_decode u_dec (
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .all_banks (addr[ALL_BIT]),
    .cmd       (cmd)
  );

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign act_en[b] = (cmd == CMD_ACT) && (ba == BA_W'(b)) && ready_v[b] && !open_v[b];
      assign pre_en[b] = (cmd == CMD_PALL) || ((cmd == CMD_PRE) && (ba == BA_W'(b)));
      sdr_bank_slot #(.ROW_W(ADDR_W), .TRP(TRP)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .act_en  (act_en[b]),
        .pre_en  (pre_en[b]),
        .row_in  (addr),
        .is_open (open_v[b]),
        .ready   (ready_v[b]),
        .row_q   (row_q[b])
      );
    end
  endgenerate

  always_comb begin
    unique case (cmd)
      CMD_ACT:        viol_c = !(ready_v[ba] && !open_v[ba]);
      CMD_RD, CMD_WR: viol_c = !open_v[ba];
      default:        viol_c = 1'b0;
    endcase
  end

  assign rd_ok   = (cmd == CMD_RD) && open_v[ba];
  assign wr_ok   = (cmd == CMD_WR) && open_v[ba];
  assign col_ext = ADDR_W'(addr[COL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code <= '0;
      cmd_bank <= '0;
      cmd_addr <= '0;
      cmd_row  <= '0;
      viol     <= 1'b0;
    end else begin
      cmd_code <= cmd;
      cmd_bank <= (cmd == CMD_NOP) ? '0 : ba;
      viol     <= viol_c;
      unique case (cmd)
        CMD_ACT:        cmd_addr <= addr;
        CMD_RD, CMD_WR: cmd_addr <= col_ext;
        default:        cmd_addr <= '0;
      endcase
      cmd_row <= (rd_ok || wr_ok) ? row_q[ba] : '0;
    end
  end

  sdr_burst_strobe #(.MAX_DLY(MAX_CL), .DLY_W(CL_W)) u_rd_strb (
    .clk    (clk),
    .rst    (rst),
    .start  (rd_ok),
    .dly    (cas_lat),
    .bl_sel (burst_sel),
    .strobe (rd_valid)
  );

  sdr_burst_strobe #(.MAX_DLY(MAX_CL), .DLY_W(CL_W)) u_wr_strb (
    .clk    (clk),
    .rst    (rst),
    .start  (wr_ok),
    .dly    ('0),
    .bl_sel (burst_sel),
    .strobe (wr_capture)
  );

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdr_trk_pkg::*;
#(
  parameter int TRP  = 3,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cmd_code,
  input logic [BA_W-1:0] cmd_bank,
  input logic            viol,
  input logic            wr_capture
);

  // R2
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_NOP) |-> !viol);

  // R5
  pre_never_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_PRE || cmd_code == CMD_PALL) |-> !viol);

  // R3
  double_act_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_ACT && !viol && $past(cmd_code == CMD_ACT && !viol))
      |-> (cmd_bank != $past(cmd_bank)));

  // R6
  early_act_chk: assert property (@(posedge clk) disable iff (rst)
    (TRP > 1 && cmd_code == CMD_ACT && $past(cmd_code) == CMD_PALL) |-> viol);

  // R8
  wr_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_capture) |-> (cmd_code == CMD_WR && !viol));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.TRP(TRP), .BA_W(BA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_code   (cmd_code),
  .cmd_bank   (cmd_bank),
  .viol       (viol),
  .wr_capture (wr_capture)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  localparam int TRP   = 3;
  localparam int COL_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  cas_lat = 2'd1;
  logic [1:0]  burst_sel = 2'd0;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr, cmd_row;
  logic        viol, rd_valid, wr_capture;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cas_lat(cas_lat), .burst_sel(burst_sel),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_row(cmd_row),
    .viol(viol), .rd_valid(rd_valid), .wr_capture(wr_capture)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit mon_en = 0;

  // independent bank model
  bit m_open [4];
  int m_row  [4];
  int m_pre  [4];
  int rd_s [0:255];
  int wr_s [0:255];
  int n_rd = 0, n_wr = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(bit c, bit r, bit ca, bit w, bit a10);
    if (c) return 0;
    case ({r, ca, w})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return a10 ? 5 : 4;
      default: return 0;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_row[i] = 0; m_pre[i] = -1000;
    end
    n_rd = 0; n_wr = 0;
  endtask

  // called at a negedge; drives, waits one edge, checks the report
  task automatic do_cmd(input bit c, input bit r, input bit ca, input bit w,
                        input int b, input int a, input string tag);
    int code, n, e_bank, e_addr, e_row;
    bit e_viol;
    logic [29:0] act, exp;
    code = exp_code(c, r, ca, w, a[10]);
    n = cyc + 1;
    e_viol = 0; e_addr = 0; e_row = 0;
    e_bank = (code == 0) ? 0 : b;
    case (code)
      1: begin
        e_addr = a;
        e_viol = m_open[b] || (n - m_pre[b] < TRP);
        if (!e_viol) begin m_open[b] = 1; m_row[b] = a; end
      end
      2, 3: begin
        e_addr = a & ((1 << COL_W) - 1);
        e_viol = !m_open[b];
        if (!e_viol) begin
          e_row = m_row[b];
          if (code == 2) begin rd_s[n_rd] = n + int'(cas_lat); n_rd++; end
          else begin wr_s[n_wr] = n; n_wr++; end
        end
      end
      4: begin m_open[b] = 0; m_pre[b] = n; end
      5: for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_pre[i] = n; end
      default: ;
    endcase
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b[1:0]; addr = a[11:0];
    @(negedge clk);
    act = {cmd_code, cmd_bank, cmd_addr, cmd_row, viol};
    exp = {3'(code), 2'(e_bank), 12'(e_addr), 12'(e_row), e_viol};
    check(act == exp, tag, 64'(act), 64'(exp));
  endtask

  task automatic nop(input int k);
    for (int i = 0; i < k; i++) do_cmd(1, 1, 1, 1, 0, 0, "R2 idle");
  endtask
  task automatic act_c(input int b, input int row, input string tag);
    do_cmd(0, 0, 1, 1, b, row, tag);
  endtask
  task automatic rd_c(input int b, input int col, input string tag);
    do_cmd(0, 1, 0, 1, b, col, tag);
  endtask
  task automatic wr_c(input int b, input int col, input string tag);
    do_cmd(0, 1, 0, 0, b, col, tag);
  endtask
  task automatic pre_c(input int b, input string tag);
    do_cmd(0, 0, 1, 0, b, 0, tag);
  endtask
  task automatic pall_c(input int b, input string tag);
    do_cmd(0, 0, 1, 0, b, 12'h400, tag);
  endtask

  task automatic do_reset(input int cl, input int bl);
    mon_en = 0;
    rst = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    cas_lat = cl[1:0]; burst_sel = bl[1:0];
    repeat (3) @(negedge clk);
    model_clear();
    rst = 0;
    check({cmd_code, cmd_bank, cmd_addr, cmd_row, viol, rd_valid, wr_capture} == '0,
          "R11 reset outputs", 64'({cmd_code, cmd_bank, cmd_addr, cmd_row, viol, rd_valid, wr_capture}), 0);
    mon_en = 1;
  endtask

  // per-cycle strobe monitor
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      int e, beats;
      bit er, ew;
      e = cyc; beats = 1 << burst_sel; er = 0; ew = 0;
      for (int i = 0; i < n_rd; i++) if (e >= rd_s[i] && e <= rd_s[i] + beats - 1) er = 1;
      for (int i = 0; i < n_wr; i++) if (e >= wr_s[i] && e <= wr_s[i] + beats - 1) ew = 1;
      check(rd_valid == er, "R9/R10 rd_valid window", 64'(rd_valid), 64'(er));
      check(wr_capture == ew, "R8/R10 wr_capture window", 64'(wr_capture), 64'(ew));
    end
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(2, 2);
    // R11: every bank idle after reset
    for (int b = 0; b < 4; b++) rd_c(b, 3, "R11 idle after reset");
    for (int b = 0; b < 4; b++) act_c(b, 12'h100 + b, "R11 ready after reset");

    // R1/R2 decode sweep over all strobe patterns and both a10 values
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 16; i++) begin
        int a = pass ? 12'h4AB : 12'h0AB;
        bit c = i[3], r = i[2], ca = i[1], w = i[0];
        do_cmd(c, r, ca, w, 1, a, exp_code(c, r, ca, w, a[10]) == 0 ? "R2 nop pattern" : "R1 decode");
        nop(TRP);
        act_c(1, 12'h2C0 + i, "R3 reopen");
        rd_c(1, 12'hFF7, "R12 column zero-extend");
        nop(8);
      end
    end

    // R6 lockout sweep per bank and gap
    do_reset(1, 0);
    for (int b = 0; b < 4; b++) begin
      for (int k = 1; k <= TRP + 1; k++) begin
        pre_c(b, "R4 single precharge");
        nop(k - 1);
        act_c(b, 12'h300 + k, "R6 lockout gap");
        rd_c(b, 1, "R6 state after activate");
        nop(TRP);
      end
    end

    // R3 activate to an open bank; R4 single; R5 all
    do_reset(1, 0);
    for (int b = 0; b < 4; b++) act_c(b, 12'h500 + b, "R3 open");
    act_c(2, 12'h777, "R3 activate open bank");
    rd_c(2, 4, "R3 row kept");
    pre_c(2, "R4 precharge bank 2");
    for (int b = 0; b < 4; b++) rd_c(b, 0, "R4 only selected bank closed");
    pall_c(3, "R5 precharge all");
    act_c(1, 12'h111, "R6 activate right after all-bank precharge");
    for (int b = 0; b < 4; b++) wr_c(b, 0, "R5 all banks closed");
    nop(TRP);
    for (int b = 0; b < 4; b++) act_c(b, 12'h600 + b, "R5 reopen after lockout");
    pall_c(0, "R5 precharge all from bank 0");
    for (int b = 0; b < 4; b++) rd_c(b, 0, "R5 closed again");

    // strobe sweep over CAS latency and burst length
    for (int cl = 1; cl <= 3; cl++) begin
      for (int bl = 0; bl < 4; bl++) begin
        do_reset(cl, bl);
        act_c(0, 12'h0A5, "R3 open for bursts");
        rd_c(0, 5, "R9 read");
        wr_c(0, 6, "R8 write overlapping read");
        nop(14);
        wr_c(0, 1, "R8 write first");
        rd_c(0, 2, "R9 read after write");
        nop(14);
        rd_c(0, 1, "R10 read");
        rd_c(0, 2, "R10 read restart");
        wr_c(0, 3, "R10 write");
        wr_c(0, 4, "R10 write restart");
        nop(14);
        rd_c(1, 0, "R7 read idle bank");
        wr_c(2, 0, "R7 write idle bank");
        nop(14);
        pre_c(0, "R4 close");
        rd_c(0, 0, "R7 read after close");
        nop(14);
      end
    end

    mon_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule